// File: doc/BRIEF.md
# Multicycle Instruction-Cycle Controller

This block is the sequencing controller of a small 32-bit load/store processor built as a multicycle machine. It steps the datapath through the instruction cycle one phase per clock. Each cycle it raises the strobes for that phase: program-counter write, instruction-register load, memory read, memory write, register-file write, memory address source, ALU operand-B source, ALU operation class, destination-register choice, write-back result choice and next-PC source. The PC, memory, register file and ALU sit outside the block.

The path through the phases depends on the instruction class taken from the 6-bit opcode held in the instruction register. Loads use all five phases. ALU register operations skip the memory phase. Stores finish after the memory phase, and branches finish after execute. Jump-and-link writes the return address and redirects the PC in its write-back phase. The PC is advanced by 4 during fetch, so the PC value seen in later phases is already the sequential successor. A build parameter selects a binary or a one-hot state register; the phase code at the port is the same for both.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high every strobe (`pc_wr`, `ir_ld`, `mem_rd`, `mem_wr`, `rf_wr`, `alu_b_imm`, `mem_addr_alu`) is 0 and every select is 0. The first cycle after reset is Fetch. Reset is synchronous and takes effect from any phase.
- R2: Each phase lasts one clock. The `phase` output codes are Fetch=0, Decode=1, Execute=2, Memory=3, WriteBack=4. Fetch is always followed by Decode, and WriteBack is always followed by Fetch.
- R3: In Fetch the block asserts `mem_rd`, `ir_ld` and `pc_wr` with `pc_sel`=0 (PC+4) and `mem_addr_alu`=0 (address from the PC). All other outputs keep their defaults.
- R4: In Decode no strobe is asserted. An opcode outside the five recognised ones returns to Fetch straight after Decode and raises no write strobe.
- R5: R-type (opcode 000000) runs Fetch, Decode, Execute, WriteBack. In Execute `alu_cls`=2'b10 (funct decides) and `alu_b_imm`=0. In WriteBack `rf_wr`=1, `dst_sel`=1 (rd), `res_sel`=0 (ALU), and `rf_waddr` equals `rd_idx`.
- R6: Load (opcode 100011) runs all five phases. In Execute `alu_cls`=2'b00 (add) and `alu_b_imm`=1. In Memory `mem_rd`=1 and `mem_addr_alu`=1. In WriteBack `rf_wr`=1, `dst_sel`=0 (rt), `res_sel`=1 (memory), and `rf_waddr` equals `rt_idx`.
- R7: Store (opcode 101011) uses the Execute settings of R6. In Memory it asserts `mem_wr`=1 with `mem_addr_alu`=1, then returns to Fetch.
- R8: Branch-if-equal (opcode 000100) sets `alu_cls`=2'b01 (subtract) in Execute. When `alu_zero` is 1 it asserts `pc_wr` with `pc_sel`=1 (branch target); otherwise both stay 0. It then returns to Fetch. `alu_zero` has no effect for any other opcode.
- R9: Jump-and-link (opcode 000011) passes through Execute with no strobe. In WriteBack it asserts `rf_wr` with `dst_sel`=2 and `res_sel`=2 (current PC, i.e. PC+4), and `rf_waddr`=31. In the same cycle it asserts `pc_wr` with `pc_sel`=2 (jump target).
- R10: `mem_wr` is asserted only in the Memory phase of a store. `rf_wr` is asserted only in WriteBack.
- R11: Only the phase codes 0 to 4 appear on `phase`, whichever state-register encoding is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| rt_idx | input | 5 | rt register index field |
| rd_idx | input | 5 | rd register index field |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc_wr | output | 1 | PC write enable |
| ir_ld | output | 1 | Instruction register load |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr_alu | output | 1 | Memory address from ALU output (0: from PC) |
| rf_wr | output | 1 | Register-file write enable |
| alu_b_imm | output | 1 | ALU operand B is the sign-extended immediate |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 funct |
| dst_sel | output | 2 | Destination: 0 rt, 1 rd, 2 link |
| res_sel | output | 2 | Write-back data: 0 ALU, 1 memory, 2 PC |
| pc_sel | output | 2 | Next PC: 0 PC+4, 1 branch target, 2 jump target |
| rf_waddr | output | 5 | Register-file write index |
| phase | output | 3 | Current phase code |

## Verification
Some properties are checked on every cycle: the Fetch-to-Decode and WriteBack-to-Fetch successions, the quiet outputs during reset, the Fetch strobes, that memory and register writes appear only in their own phases, that the branch PC write follows the zero flag, that stores and unknown opcodes return to Fetch, the link index, and that the phase code stays legal. The directed scenarios are needed for the rest. They show the full per-class phase sequence and the exact select values in each phase. They also show that `alu_zero` has no effect on an R-type instruction, and that a reset in mid-instruction abandons it and restarts at Fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

   localparam int NUM_PH = 5;

   typedef enum logic [2:0] {
      PH_FETCH  = 3'd0,
      PH_DECODE = 3'd1,
      PH_EXEC   = 3'd2,
      PH_MEM    = 3'd3,
      PH_WB     = 3'd4
   } phase_e;

   typedef enum logic [2:0] {
      IC_NONE,
      IC_ALU,
      IC_LOAD,
      IC_STORE,
      IC_BRANCH,
      IC_LINKJMP
   } iclass_e;

   typedef enum logic [1:0] {
      DS_RT   = 2'd0,
      DS_RD   = 2'd1,
      DS_LINK = 2'd2
   } dst_e;

   typedef enum logic [1:0] {
      RS_ALU  = 2'd0,
      RS_MEM  = 2'd1,
      RS_LINK = 2'd2
   } res_e;

   typedef enum logic [1:0] {
      PS_SEQ    = 2'd0,
      PS_BRANCH = 2'd1,
      PS_JUMP   = 2'd2
   } pcs_e;

   localparam logic [1:0] AC_ADD   = 2'b00;
   localparam logic [1:0] AC_SUB   = 2'b01;
   localparam logic [1:0] AC_FUNCT = 2'b10;

   typedef struct packed {
      logic       pc_wr;
      logic       ir_ld;
      logic       mem_rd;
      logic       mem_wr;
      logic       rf_wr;
      logic       alu_b_imm;
      logic       addr_alu;
      logic [1:0] alu_cls;
      dst_e       dst;
      res_e       res;
      pcs_e       pcs;
   } ctrl_s;

endpackage

// File: rtl/mc_op_classify.sv
module mc_op_classify
   import mc_ctrl_pkg::*;
#(
   parameter int                OPC_W    = 6,
   parameter logic [OPC_W-1:0]  OP_RTYPE = 6'b000000,
   parameter logic [OPC_W-1:0]  OP_LOAD  = 6'b100011,
   parameter logic [OPC_W-1:0]  OP_STORE = 6'b101011,
   parameter logic [OPC_W-1:0]  OP_BEQ   = 6'b000100,
   parameter logic [OPC_W-1:0]  OP_JAL   = 6'b000011
) (
   input  logic [OPC_W-1:0] opcode,
   output iclass_e          cls
);

   localparam int NUM_OPS = 5;
   localparam logic [NUM_OPS*OPC_W-1:0] OP_LIST =
      {OP_JAL, OP_BEQ, OP_STORE, OP_LOAD, OP_RTYPE};

   // every recognised opcode must be distinct
   for (genvar i = 0; i < NUM_OPS; i++) begin : g_uniq_i
      for (genvar j = i + 1; j < NUM_OPS; j++) begin : g_uniq_j
         if (OP_LIST[i*OPC_W +: OPC_W] == OP_LIST[j*OPC_W +: OPC_W]) begin : g_dup
            $error("mc_op_classify: opcodes %0d and %0d collide", i, j);
         end
      end
   end

   always_comb begin
      if (opcode == OP_RTYPE)      cls = IC_ALU;
      else if (opcode == OP_LOAD)  cls = IC_LOAD;
      else if (opcode == OP_STORE) cls = IC_STORE;
      else if (opcode == OP_BEQ)   cls = IC_BRANCH;
      else if (opcode == OP_JAL)   cls = IC_LINKJMP;
      else                         cls = IC_NONE;
   end

endmodule

// File: rtl/mc_state_seq.sv
module mc_state_seq
   import mc_ctrl_pkg::*;
#(
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic    clk,
   input  logic    rst,
   input  iclass_e cls,
   output phase_e  phase
);

   phase_e nxt;

   // successor phase from current phase and instruction class
   always_comb begin
      nxt = PH_FETCH;
      unique case (phase)
         PH_FETCH:  nxt = PH_DECODE;
         PH_DECODE: nxt = (cls == IC_NONE) ? PH_FETCH : PH_EXEC;
         PH_EXEC: begin
            case (cls)
               IC_ALU, IC_LINKJMP: nxt = PH_WB;
               IC_LOAD, IC_STORE:  nxt = PH_MEM;
               default:            nxt = PH_FETCH;
            endcase
         end
         PH_MEM:    nxt = (cls == IC_LOAD) ? PH_WB : PH_FETCH;
         PH_WB:     nxt = PH_FETCH;
         default:   nxt = PH_FETCH;
      endcase
   end

   if (ONEHOT_STATE) begin : g_onehot
      localparam logic [NUM_PH-1:0] OH_FETCH = {{(NUM_PH-1){1'b0}}, 1'b1};
      logic [NUM_PH-1:0] oh_q;

      always_ff @(posedge clk) begin
         if (rst) oh_q <= OH_FETCH;
         else     oh_q <= OH_FETCH << nxt;
      end

      always_comb begin
         phase = PH_FETCH;
         for (int i = 0; i < NUM_PH; i++) begin
            if (oh_q[i]) phase = phase_e'(3'(i));
         end
      end
   end else begin : g_binary
      phase_e bin_q;

      always_ff @(posedge clk) begin
         if (rst) bin_q <= PH_FETCH;
         else     bin_q <= nxt;
      end

      assign phase = bin_q;
   end

endmodule

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen
   import mc_ctrl_pkg::*;
(
   input  phase_e  phase,
   input  iclass_e cls,
   input  logic    alu_zero,
   output ctrl_s   ctrl
);

   always_comb begin
      ctrl = '0;
      case (phase)
         PH_FETCH: begin
            ctrl.mem_rd = 1'b1;
            ctrl.ir_ld  = 1'b1;
            ctrl.pc_wr  = 1'b1;
            ctrl.pcs    = PS_SEQ;
         end
         PH_EXEC: begin
            case (cls)
               IC_ALU: begin
                  ctrl.alu_cls = AC_FUNCT;
               end
               IC_LOAD, IC_STORE: begin
                  ctrl.alu_cls   = AC_ADD;
                  ctrl.alu_b_imm = 1'b1;
               end
               IC_BRANCH: begin
                  ctrl.alu_cls = AC_SUB;
                  if (alu_zero) begin
                     ctrl.pc_wr = 1'b1;
                     ctrl.pcs   = PS_BRANCH;
                  end
               end
               default: ;
            endcase
         end
         PH_MEM: begin
            if (cls == IC_LOAD) begin
               ctrl.mem_rd   = 1'b1;
               ctrl.addr_alu = 1'b1;
            end else if (cls == IC_STORE) begin
               ctrl.mem_wr   = 1'b1;
               ctrl.addr_alu = 1'b1;
            end
         end
         PH_WB: begin
            case (cls)
               IC_ALU: begin
                  ctrl.rf_wr = 1'b1;
                  ctrl.dst   = DS_RD;
                  ctrl.res   = RS_ALU;
               end
               IC_LOAD: begin
                  ctrl.rf_wr = 1'b1;
                  ctrl.dst   = DS_RT;
                  ctrl.res   = RS_MEM;
               end
               IC_LINKJMP: begin
                  ctrl.rf_wr = 1'b1;
                  ctrl.dst   = DS_LINK;
                  ctrl.res   = RS_LINK;
                  ctrl.pc_wr = 1'b1;
                  ctrl.pcs   = PS_JUMP;
               end
               default: ;
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
   import mc_ctrl_pkg::*;
#(
   parameter int                OPC_W        = 6,
   parameter int                REG_W        = 5,
   parameter int                LINK_REG     = 31,
   parameter bit                ONEHOT_STATE = 1'b0,
   parameter logic [OPC_W-1:0]  OP_RTYPE     = 6'b000000,
   parameter logic [OPC_W-1:0]  OP_LOAD      = 6'b100011,
   parameter logic [OPC_W-1:0]  OP_STORE     = 6'b101011,
   parameter logic [OPC_W-1:0]  OP_BEQ       = 6'b000100,
   parameter logic [OPC_W-1:0]  OP_JAL       = 6'b000011
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   input  logic [REG_W-1:0] rt_idx,
   input  logic [REG_W-1:0] rd_idx,
   input  logic             alu_zero,
   output logic             pc_wr,
   output logic             ir_ld,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             mem_addr_alu,
   output logic             rf_wr,
   output logic             alu_b_imm,
   output logic [1:0]       alu_cls,
   output logic [1:0]       dst_sel,
   output logic [1:0]       res_sel,
   output logic [1:0]       pc_sel,
   output logic [REG_W-1:0] rf_waddr,
   output logic [2:0]       phase
);

   localparam int NUM_REGS = 1 << REG_W;
   localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

   if (LINK_REG < 0 || LINK_REG >= NUM_REGS) begin : g_bad_link
      $error("mc_ctrl_fsm: LINK_REG %0d outside register file", LINK_REG);
   end
   if (OPC_W < 3) begin : g_bad_opc
      $error("mc_ctrl_fsm: OPC_W too small for five opcodes");
   end

   iclass_e cls;
   phase_e  ph;
   ctrl_s   ctrl_raw;
   ctrl_s   ctrl_g;

   mc_op_classify #(
      .OPC_W    (OPC_W),
      .OP_RTYPE (OP_RTYPE),
      .OP_LOAD  (OP_LOAD),
      .OP_STORE (OP_STORE),
      .OP_BEQ   (OP_BEQ),
      .OP_JAL   (OP_JAL)
   ) u_cls (
      .opcode (opcode),
      .cls    (cls)
   );

   mc_state_seq #(
      .ONEHOT_STATE (ONEHOT_STATE)
   ) u_seq (
      .clk   (clk),
      .rst   (rst),
      .cls   (cls),
      .phase (ph)
   );

   mc_strobe_gen u_strb (
      .phase    (ph),
      .cls      (cls),
      .alu_zero (alu_zero),
      .ctrl     (ctrl_raw)
   );

   // hold every strobe low while reset is applied
   assign ctrl_g = rst ? '0 : ctrl_raw;

   assign pc_wr        = ctrl_g.pc_wr;
   assign ir_ld        = ctrl_g.ir_ld;
   assign mem_rd       = ctrl_g.mem_rd;
   assign mem_wr       = ctrl_g.mem_wr;
   assign mem_addr_alu = ctrl_g.addr_alu;
   assign rf_wr        = ctrl_g.rf_wr;
   assign alu_b_imm    = ctrl_g.alu_b_imm;
   assign alu_cls      = ctrl_g.alu_cls;
   assign dst_sel      = ctrl_g.dst;
   assign res_sel      = ctrl_g.res;
   assign pc_sel       = ctrl_g.pcs;
   assign phase        = ph;

   always_comb begin
      case (ctrl_g.dst)
         DS_RD:   rf_waddr = rd_idx;
         DS_LINK: rf_waddr = LINK_IDX;
         default: rf_waddr = rt_idx;
      endcase
   end

endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk #(
   parameter int               OPC_W    = 6,
   parameter int               REG_W    = 5,
   parameter int               LINK_REG = 31,
   parameter logic [OPC_W-1:0] OP_RTYPE = 6'b000000,
   parameter logic [OPC_W-1:0] OP_LOAD  = 6'b100011,
   parameter logic [OPC_W-1:0] OP_STORE = 6'b101011,
   parameter logic [OPC_W-1:0] OP_BEQ   = 6'b000100,
   parameter logic [OPC_W-1:0] OP_JAL   = 6'b000011
) (
   input logic             clk,
   input logic             rst,
   input logic [OPC_W-1:0] opcode,
   input logic             alu_zero,
   input logic             pc_wr,
   input logic             ir_ld,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             rf_wr,
   input logic [1:0]       dst_sel,
   input logic [1:0]       pc_sel,
   input logic [REG_W-1:0] rf_waddr,
   input logic [2:0]       phase
);

   localparam logic [2:0] C_FETCH = 3'd0;
   localparam logic [2:0] C_DEC   = 3'd1;
   localparam logic [2:0] C_EXEC  = 3'd2;
   localparam logic [2:0] C_MEM   = 3'd3;
   localparam logic [2:0] C_WB    = 3'd4;

   logic known_op;
   assign known_op = (opcode == OP_RTYPE) || (opcode == OP_LOAD) || (opcode == OP_STORE)
                  || (opcode == OP_BEQ) || (opcode == OP_JAL);

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |-> !(pc_wr || ir_ld || mem_rd || mem_wr || rf_wr));

   p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
      (phase == C_FETCH) |=> (phase == C_DEC));

   p_wb_next_r2: assert property (@(posedge clk) disable iff (rst)
      (phase == C_WB) |=> (phase == C_FETCH));

   p_fetch_strobes_r3: assert property (@(posedge clk) disable iff (rst)
      (phase == C_FETCH) |-> (pc_wr && ir_ld && mem_rd && pc_sel == 2'd0));

   p_decode_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == C_DEC) |-> !(pc_wr || ir_ld || mem_rd || mem_wr || rf_wr));

   p_unknown_back_r4: assert property (@(posedge clk) disable iff (rst)
      (phase == C_DEC && !known_op) |=> (phase == C_FETCH));

   p_store_ends_r7: assert property (@(posedge clk) disable iff (rst)
      (phase == C_MEM && opcode == OP_STORE) |=> (phase == C_FETCH));

   p_branch_pc_r8: assert property (@(posedge clk) disable iff (rst)
      (phase == C_EXEC && opcode == OP_BEQ) |->
         (pc_wr == alu_zero && pc_sel == (alu_zero ? 2'd1 : 2'd0)));

   p_link_index_r9: assert property (@(posedge clk) disable iff (rst)
      (rf_wr && dst_sel == 2'd2) |-> (rf_waddr == REG_W'(LINK_REG)));

   p_memwr_store_r10: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> (phase == C_MEM && opcode == OP_STORE));

   p_rfwr_wb_r10: assert property (@(posedge clk) disable iff (rst)
      rf_wr |-> (phase == C_WB));

   p_phase_legal_r11: assert property (@(posedge clk) disable iff (rst)
      phase <= C_WB);

endmodule

bind mc_ctrl_fsm mc_ctrl_chk #(
   .OPC_W    (OPC_W),
   .REG_W    (REG_W),
   .LINK_REG (LINK_REG),
   .OP_RTYPE (OP_RTYPE),
   .OP_LOAD  (OP_LOAD),
   .OP_STORE (OP_STORE),
   .OP_BEQ   (OP_BEQ),
   .OP_JAL   (OP_JAL)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .opcode   (opcode),
   .alu_zero (alu_zero),
   .pc_wr    (pc_wr),
   .ir_ld    (ir_ld),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .rf_wr    (rf_wr),
   .dst_sel  (dst_sel),
   .pc_sel   (pc_sel),
   .rf_waddr (rf_waddr),
   .phase    (phase)
);

// File: tb/sim_mc_ctrl_fsm.sv
module sim_mc_ctrl_fsm;
   import mc_ctrl_pkg::*;

   localparam time TCLK = 10ns;
   localparam logic [4:0] RT = 5'd7;
   localparam logic [4:0] RD = 5'd12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'b111111;
   logic [4:0] rt_idx = RT;
   logic [4:0] rd_idx = RD;
   logic       alu_zero = 1'b0;
   logic       pc_wr, ir_ld, mem_rd, mem_wr, mem_addr_alu, rf_wr, alu_b_imm;
   logic [1:0] alu_cls, dst_sel, res_sel, pc_sel;
   logic [4:0] rf_waddr;
   logic [2:0] phase;

   int n_vec = 0;
   int n_bad = 0;

   always #(TCLK/2) clk = ~clk;

   mc_ctrl_fsm u0 (
      .clk(clk), .rst(rst), .opcode(opcode), .rt_idx(rt_idx), .rd_idx(rd_idx),
      .alu_zero(alu_zero), .pc_wr(pc_wr), .ir_ld(ir_ld), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_addr_alu(mem_addr_alu), .rf_wr(rf_wr),
      .alu_b_imm(alu_b_imm), .alu_cls(alu_cls), .dst_sel(dst_sel),
      .res_sel(res_sel), .pc_sel(pc_sel), .rf_waddr(rf_waddr), .phase(phase)
   );

   ctrl_s act;
   always_comb begin
      act.pc_wr     = pc_wr;
      act.ir_ld     = ir_ld;
      act.mem_rd    = mem_rd;
      act.mem_wr    = mem_wr;
      act.rf_wr     = rf_wr;
      act.alu_b_imm = alu_b_imm;
      act.addr_alu  = mem_addr_alu;
      act.alu_cls   = alu_cls;
      act.dst       = dst_e'(dst_sel);
      act.res       = res_e'(res_sel);
      act.pcs       = pcs_e'(pc_sel);
   end

   task automatic tick();
      @(negedge clk);
   endtask

   function automatic ctrl_s quiet();
      ctrl_s c;
      c = '0;
      return c;
   endfunction

   function automatic ctrl_s fetch_exp();
      ctrl_s c;
      c = '0;
      c.pc_wr  = 1'b1;
      c.ir_ld  = 1'b1;
      c.mem_rd = 1'b1;
      return c;
   endfunction

   task automatic cmp(string req, phase_e eph, ctrl_s ec, logic [4:0] ewa);
      n_vec++;
      if ({phase, act, rf_waddr} !== {eph, ec, ewa}) begin
         n_bad++;
         $display("FAIL %s: actual phase=%0d ctrl=%h waddr=%0d expected phase=%0d ctrl=%h waddr=%0d",
                  req, phase, act, rf_waddr, eph, ec, ewa);
      end
   endtask

   // enters in a Fetch cycle, leaves at the start of Execute (or Fetch)
   task automatic fetch_decode(string req, logic [5:0] op);
      cmp({req, "/R3 fetch"}, PH_FETCH, fetch_exp(), RT);
      opcode = op;
      tick();
      cmp({req, "/R4 decode"}, PH_DECODE, quiet(), RT);
      tick();
   endtask

   task automatic t_reset();
      tick();
      cmp("R1 reset quiet", PH_FETCH, quiet(), RT);
      rst = 1'b0;
      #1;
      cmp("R1 first fetch", PH_FETCH, fetch_exp(), RT);
   endtask

   task automatic t_rtype();
      ctrl_s c;
      alu_zero = 1'b1;   // R8: must not affect an R-type
      fetch_decode("R5", 6'b000000);
      c = quiet(); c.alu_cls = AC_FUNCT;
      cmp("R5 execute (R8 zero ignored)", PH_EXEC, c, RT);
      tick();
      c = quiet(); c.rf_wr = 1'b1; c.dst = DS_RD; c.res = RS_ALU;
      cmp("R5 writeback rd", PH_WB, c, RD);
      tick();
      alu_zero = 1'b0;
      cmp("R2 wb then fetch", PH_FETCH, fetch_exp(), RT);
   endtask

   task automatic t_load();
      ctrl_s c;
      fetch_decode("R6", 6'b100011);
      c = quiet(); c.alu_cls = AC_ADD; c.alu_b_imm = 1'b1;
      cmp("R6 execute", PH_EXEC, c, RT);
      tick();
      c = quiet(); c.mem_rd = 1'b1; c.addr_alu = 1'b1;
      cmp("R6 memory", PH_MEM, c, RT);
      tick();
      c = quiet(); c.rf_wr = 1'b1; c.dst = DS_RT; c.res = RS_MEM;
      cmp("R6 writeback", PH_WB, c, RT);
      tick();
   endtask

   task automatic t_store();
      ctrl_s c;
      fetch_decode("R7", 6'b101011);
      c = quiet(); c.alu_cls = AC_ADD; c.alu_b_imm = 1'b1;
      cmp("R7 execute", PH_EXEC, c, RT);
      tick();
      c = quiet(); c.mem_wr = 1'b1; c.addr_alu = 1'b1;
      cmp("R7 memory write (R10)", PH_MEM, c, RT);
      tick();
      cmp("R7 back to fetch", PH_FETCH, fetch_exp(), RT);
   endtask

   task automatic t_branch(logic z);
      ctrl_s c;
      alu_zero = z;
      fetch_decode("R8", 6'b000100);
      c = quiet(); c.alu_cls = AC_SUB;
      if (z) begin c.pc_wr = 1'b1; c.pcs = PS_BRANCH; end
      cmp(z ? "R8 branch taken" : "R8 branch not taken", PH_EXEC, c, RT);
      tick();
      alu_zero = 1'b0;
      cmp("R8 back to fetch", PH_FETCH, fetch_exp(), RT);
   endtask

   task automatic t_jal();
      ctrl_s c;
      fetch_decode("R9", 6'b000011);
      cmp("R9 execute quiet", PH_EXEC, quiet(), RT);
      tick();
      c = quiet(); c.rf_wr = 1'b1; c.dst = DS_LINK; c.res = RS_LINK;
      c.pc_wr = 1'b1; c.pcs = PS_JUMP;
      cmp("R9 link write and jump", PH_WB, c, 5'd31);
      tick();
   endtask

   task automatic t_unknown();
      fetch_decode("R4", 6'b111110);
      cmp("R4 unknown returns to fetch", PH_FETCH, fetch_exp(), RT);
   endtask

   task automatic t_mid_reset();
      ctrl_s c;
      fetch_decode("R1", 6'b100011);
      c = quiet(); c.alu_cls = AC_ADD; c.alu_b_imm = 1'b1;
      cmp("R1 load execute before reset", PH_EXEC, c, RT);
      rst = 1'b1;
      #1;
      cmp("R1 strobes low under reset", PH_EXEC, quiet(), RT);
      tick();
      cmp("R1 reset forces fetch", PH_FETCH, quiet(), RT);
      rst = 1'b0;
      #1;
      cmp("R1 fetch after reset", PH_FETCH, fetch_exp(), RT);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual run still active, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : main
      t_reset();
      t_rtype();
      t_load();
      cmp("R2 load wb then fetch", PH_FETCH, fetch_exp(), RT);
      t_store();
      t_branch(1'b1);
      t_branch(1'b0);
      t_jal();
      cmp("R9 back to fetch", PH_FETCH, fetch_exp(), RT);
      t_unknown();
      t_mid_reset();
      t_rtype();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule